// File: doc/BRIEF.md
# Packed 16-bit Widening Multiply Unit

This unit multiplies the two 16-bit halves of one source word by the two 16-bit halves of a second source word. Both products run in parallel and each keeps all 32 bits. A mode input chooses between two's-complement and plain binary operands. A second mode input chooses the lane pairing. In straight pairing, the top half meets the top half and the bottom half meets the bottom half. In crossed pairing, the first source's top half meets the second source's bottom half, and the first source's bottom half meets the second source's top half. Only the least significant 32 bits of each source are read. No shift, rounding, saturation or overflow reporting is applied.

The unit sits in an execute pipeline behind instruction decode and has one register stage. When `in_valid` is high at a clock edge, the results appear with `out_valid` one clock later. The parameter `XLEN` selects how the results leave the unit. With `XLEN` = 32 there are two register-file write ports, and both are active in the same cycle. They address an even/odd register pair formed from destination index bits 4:1. With `XLEN` = 64 the two products are packed into one 64-bit word and the write ports stay idle.

Top module: `simd_mul16_wide`

## Requirements
- R1: Only bits 31:0 of `src_a` and `src_b` affect any result. With `XLEN` = 64, bits 63:32 of either source have no effect on `packed_out`.
- R2: With `signed_mode` = 1, the halves are two's-complement and each product is their exact 32-bit signed product. 0x8000 times 0x8000 gives 0x40000000, and 0xFFFF times 0xFFFF gives 0x00000001.
- R3: With `signed_mode` = 0, the halves are unsigned and each product is their exact 32-bit unsigned product. 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R4: With `cross_mode` = 0 (straight), the top product is a[31:16] times b[31:16] and the bottom product is a[15:0] times b[15:0].
- R5: With `cross_mode` = 1 (crossed), the top product is a[31:16] times b[15:0] and the bottom product is a[15:0] times b[31:16].
- R6: With `XLEN` = 32, let d = `dst_idx[4:1]`. `wr_hi_addr` = 2d+1 carries the top product and `wr_lo_addr` = 2d carries the bottom product. `dst_idx[0]` has no effect.
- R7: With `XLEN` = 64, `packed_out[63:32]` holds the top product and `packed_out[31:0]` holds the bottom product.
- R8: `out_valid` in a cycle equals `in_valid` at the previous clock edge, and the results in that cycle belong to that input. Back-to-back inputs give back-to-back results.
- R9: With `XLEN` = 32, `wr_hi_en` and `wr_lo_en` are both high exactly in cycles where `out_valid` is high. With `XLEN` = 64 they are never high.
- R10: A clock edge with `rst` high clears `out_valid` and both write enables, even if `in_valid` is high at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and modes are valid this cycle |
| signed_mode | input | 1 | 1: two's-complement halves, 0: unsigned halves |
| cross_mode | input | 1 | 1: crossed lane pairing, 0: straight |
| src_a | input | XLEN | First source; bits 31:0 used |
| src_b | input | XLEN | Second source; bits 31:0 used |
| dst_idx | input | 5 | Destination register index; bits 4:1 pick the pair |
| out_valid | output | 1 | Results valid this cycle |
| wr_hi_en | output | 1 | Write enable, odd register of the pair |
| wr_hi_addr | output | 5 | Odd register address (2d+1) |
| wr_hi_data | output | 32 | Product from the first source's top half |
| wr_lo_en | output | 1 | Write enable, even register of the pair |
| wr_lo_addr | output | 5 | Even register address (2d) |
| wr_lo_data | output | 32 | Product from the first source's bottom half |
| packed_out | output | 64 | Packed products, used when XLEN = 64 |

## Verification
The bound checker compares every valid result with an arithmetic model of the captured operands, for both lanes and both pairings. It also checks the following on every cycle:
- the one-cycle link between `in_valid` and `out_valid`;
- that the write enables follow `out_valid`, and that no writes happen in the packed configuration;
- the odd/even pair addresses;
- the clearing effect of reset.

Some behaviour can only be shown by the bench scenarios, which set chosen inputs and compare against known values:
- the exact boundary values 0x40000000 and 0xFFFE0001;
- that the upper source bits and index bit 0 are truly ignored;
- that a reset overrides an input arriving at the same edge.

// File: rtl/smw_pkg.sv
package smw_pkg;

    localparam int HALF_W = 16;
    localparam int PROD_W = 2 * HALF_W;
    localparam int WORD_W = 2 * HALF_W;
    localparam int ADDR_W = 5;
    localparam int PAIR_W = ADDR_W - 1;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [PROD_W-1:0] prod_t;
    typedef logic [ADDR_W-1:0] raddr_t;
    typedef logic [PAIR_W-1:0] pair_t;

    typedef enum logic {
        PAIR_STRAIGHT = 1'b0,
        PAIR_CROSSED  = 1'b1
    } pairing_e;

    typedef enum logic {
        NUM_UNSIGNED = 1'b0,
        NUM_SIGNED   = 1'b1
    } numfmt_e;

    // A source word viewed as two halfwords
    typedef struct packed {
        half_t hi;
        half_t lo;
    } word_split_t;

    // Operand pair feeding one multiplier lane
    typedef struct packed {
        half_t x;
        half_t y;
    } lane_ops_t;

    // Products named after the first source half that produced them
    typedef struct packed {
        prod_t top;
        prod_t bot;
    } prod_pair_t;

    // Extend a halfword to a full product width, by sign or by zero
    function automatic prod_t widen_half(half_t h, numfmt_e f);
        logic fill;
        fill = (f == NUM_SIGNED) & h[HALF_W-1];
        return {{HALF_W{fill}}, h};
    endfunction

    // Register address inside the even/odd pair
    function automatic raddr_t pair_addr(pair_t p, logic odd);
        return {p, odd};
    endfunction

endpackage

// File: rtl/smw_lane_route.sv
module smw_lane_route
    import smw_pkg::*;
(
    input  word_split_t a_w,
    input  word_split_t b_w,
    input  pairing_e    pairing,
    output lane_ops_t   top_ops,
    output lane_ops_t   bot_ops
);

    // The first source always keeps its position; only the second source
    // is swapped between lanes in crossed pairing.
    always_comb begin
        top_ops.x = a_w.hi;
        bot_ops.x = a_w.lo;
        if (pairing == PAIR_CROSSED) begin
            top_ops.y = b_w.lo;
            bot_ops.y = b_w.hi;
        end else begin
            top_ops.y = b_w.hi;
            bot_ops.y = b_w.lo;
        end
    end

endmodule

// File: rtl/smw_lane_mul.sv
module smw_lane_mul
    import smw_pkg::*;
(
    input  lane_ops_t ops,
    input  numfmt_e   fmt,
    output prod_t     prod
);

    // Both operands are extended to the product width. Truncating the
    // product of the extended values gives the exact signed or unsigned
    // result, so one multiplier serves both number formats.
    prod_t ext_x;
    prod_t ext_y;

    always_comb begin
        ext_x = widen_half(ops.x, fmt);
        ext_y = widen_half(ops.y, fmt);
        prod  = ext_x * ext_y;
    end

endmodule

// File: rtl/smw_out_stage.sv
module smw_out_stage
    import smw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  prod_pair_t prods_d,
    input  pair_t      pair_d,
    output logic       out_valid,
    output prod_pair_t prods_q,
    output pair_t      pair_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Data registers load only with a new operation and carry no reset
    always_ff @(posedge clk) begin
        if (in_valid) begin
            prods_q <= prods_d;
            pair_q  <= pair_d;
        end
    end

endmodule

// File: rtl/simd_mul16_wide.sv
module simd_mul16_wide
    import smw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              signed_mode,
    input  logic              cross_mode,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [ADDR_W-1:0] dst_idx,
    output logic              out_valid,
    output logic              wr_hi_en,
    output logic [ADDR_W-1:0] wr_hi_addr,
    output logic [PROD_W-1:0] wr_hi_data,
    output logic              wr_lo_en,
    output logic [ADDR_W-1:0] wr_lo_addr,
    output logic [PROD_W-1:0] wr_lo_data,
    output logic [2*PROD_W-1:0] packed_out
);

    localparam int NUM_LANES = 2;

    word_split_t a_w;
    word_split_t b_w;
    pairing_e    pairing;
    numfmt_e     fmt;
    lane_ops_t   lane_ops [NUM_LANES];
    prod_t       lane_prod [NUM_LANES];
    prod_pair_t  prods_d;
    prod_pair_t  prods_q;
    pair_t       pair_q;
    logic        unused_idx_lsb;

    assign a_w     = word_split_t'(src_a[WORD_W-1:0]);
    assign b_w     = word_split_t'(src_b[WORD_W-1:0]);
    assign pairing = pairing_e'(cross_mode);
    assign fmt     = numfmt_e'(signed_mode);
    // The pair is chosen by bits 4:1 alone
    assign unused_idx_lsb = dst_idx[0];

    smw_lane_route u_route (
        .a_w     (a_w),
        .b_w     (b_w),
        .pairing (pairing),
        .top_ops (lane_ops[1]),
        .bot_ops (lane_ops[0])
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        smw_lane_mul u_mul (
            .ops  (lane_ops[g]),
            .fmt  (fmt),
            .prod (lane_prod[g])
        );
    end

    assign prods_d.top = lane_prod[1];
    assign prods_d.bot = lane_prod[0];

    smw_out_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .prods_d   (prods_d),
        .pair_d    (dst_idx[ADDR_W-1:1]),
        .out_valid (out_valid),
        .prods_q   (prods_q),
        .pair_q    (pair_q)
    );

    if (XLEN == 32) begin : g_pair_write
        assign wr_hi_en   = out_valid;
        assign wr_lo_en   = out_valid;
        assign wr_hi_addr = pair_addr(pair_q, 1'b1);
        assign wr_lo_addr = pair_addr(pair_q, 1'b0);
        assign wr_hi_data = prods_q.top;
        assign wr_lo_data = prods_q.bot;
        assign packed_out = '0;
    end else begin : g_packed_word
        logic unused_upper;
        logic unused_pair;
        assign unused_upper = ^{src_a[XLEN-1:WORD_W], src_b[XLEN-1:WORD_W]};
        assign unused_pair  = ^pair_q;
        assign wr_hi_en   = 1'b0;
        assign wr_lo_en   = 1'b0;
        assign wr_hi_addr = '0;
        assign wr_lo_addr = '0;
        assign wr_hi_data = '0;
        assign wr_lo_data = '0;
        assign packed_out = {prods_q.top, prods_q.bot};
    end

endmodule

// File: rtl/simd_mul16_wide_chk.sv
module simd_mul16_wide_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            signed_mode,
    input logic            cross_mode,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [4:0]      dst_idx,
    input logic            out_valid,
    input logic            wr_hi_en,
    input logic [4:0]      wr_hi_addr,
    input logic [31:0]     wr_hi_data,
    input logic            wr_lo_en,
    input logic [4:0]      wr_lo_addr,
    input logic [31:0]     wr_lo_data,
    input logic [63:0]     packed_out
);

    logic [31:0] a_q, b_q;
    logic        sgn_q, crs_q;
    logic [3:0]  pair_q;

    always_ff @(posedge clk) begin
        if (in_valid) begin
            a_q    <= src_a[31:0];
            b_q    <= src_b[31:0];
            sgn_q  <= signed_mode;
            crs_q  <= cross_mode;
            pair_q <= dst_idx[4:1];
        end
    end

    function automatic logic [31:0] ref_mul(logic [15:0] x, logic [15:0] y, logic s);
        logic signed [31:0] sx, sy;
        sx = $signed(x);
        sy = $signed(y);
        if (s) return sx * sy;
        return {16'h0, x} * {16'h0, y};
    endfunction

    logic [31:0] exp_top, exp_bot, got_top, got_bot;
    always_comb begin
        exp_top = ref_mul(a_q[31:16], crs_q ? b_q[15:0] : b_q[31:16], sgn_q);
        exp_bot = ref_mul(a_q[15:0],  crs_q ? b_q[31:16] : b_q[15:0], sgn_q);
        got_top = (XLEN == 32) ? wr_hi_data : packed_out[63:32];
        got_bot = (XLEN == 32) ? wr_lo_data : packed_out[31:0];
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !wr_hi_en && !wr_lo_en)); // R10
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8
    AST_EN_GATED: assert property (@(posedge clk) disable iff (rst)
        (wr_hi_en || wr_lo_en) |-> out_valid); // R9
    AST_TOP_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> got_top == exp_top); // R4
    AST_BOT_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> got_bot == exp_bot); // R5

    if (XLEN == 32) begin : g_pair_checks
        AST_EN_BOTH: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (wr_hi_en && wr_lo_en)); // R9
        AST_PAIR_ADDR: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (wr_hi_addr == {pair_q, 1'b1} && wr_lo_addr == {pair_q, 1'b0})); // R6
    end else begin : g_packed_checks
        AST_NO_WRITES: assert property (@(posedge clk) disable iff (rst)
            !(wr_hi_en || wr_lo_en)); // R9
    end

endmodule

bind simd_mul16_wide simd_mul16_wide_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .signed_mode(signed_mode),
    .cross_mode(cross_mode), .src_a(src_a), .src_b(src_b), .dst_idx(dst_idx),
    .out_valid(out_valid), .wr_hi_en(wr_hi_en), .wr_hi_addr(wr_hi_addr),
    .wr_hi_data(wr_hi_data), .wr_lo_en(wr_lo_en), .wr_lo_addr(wr_lo_addr),
    .wr_lo_data(wr_lo_data), .packed_out(packed_out)
);

// File: tb/tb_simd_mul16_wide.sv
`timescale 1ns/1ps
module tb_simd_mul16_wide;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        signed_mode = 1'b0;
    logic        cross_mode = 1'b0;
    logic [63:0] a64 = '0;
    logic [63:0] b64 = '0;
    logic [4:0]  dst_idx = '0;

    logic        out_valid, hi_en, lo_en;
    logic [4:0]  hi_addr, lo_addr;
    logic [31:0] hi_data, lo_data;
    logic [63:0] packed32;

    logic        v64, hi_en64, lo_en64;
    logic [4:0]  hi_addr64, lo_addr64;
    logic [31:0] hi_data64, lo_data64;
    logic [63:0] packed64;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    simd_mul16_wide #(.XLEN(32)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .signed_mode(signed_mode),
        .cross_mode(cross_mode), .src_a(a64[31:0]), .src_b(b64[31:0]), .dst_idx(dst_idx),
        .out_valid(out_valid), .wr_hi_en(hi_en), .wr_hi_addr(hi_addr), .wr_hi_data(hi_data),
        .wr_lo_en(lo_en), .wr_lo_addr(lo_addr), .wr_lo_data(lo_data), .packed_out(packed32)
    );

    simd_mul16_wide #(.XLEN(64)) dut64 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .signed_mode(signed_mode),
        .cross_mode(cross_mode), .src_a(a64), .src_b(b64), .dst_idx(dst_idx),
        .out_valid(v64), .wr_hi_en(hi_en64), .wr_hi_addr(hi_addr64), .wr_hi_data(hi_data64),
        .wr_lo_en(lo_en64), .wr_lo_addr(lo_addr64), .wr_lo_data(lo_data64), .packed_out(packed64)
    );

    function automatic logic [31:0] mref(logic [15:0] x, logic [15:0] y, bit s);
        logic signed [31:0] sx, sy;
        sx = $signed(x);
        sy = $signed(y);
        if (s) return sx * sy;
        return {16'h0, x} * {16'h0, y};
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one operation, then check both configurations one cycle later
    task automatic run_op(logic [63:0] a, logic [63:0] b, bit s, bit c, logic [4:0] idx, string req);
        logic [31:0] et, eb;
        @(negedge clk);
        a64 = a; b64 = b; signed_mode = s; cross_mode = c; dst_idx = idx; in_valid = 1'b1;
        et = mref(a[31:16], c ? b[15:0] : b[31:16], s);
        eb = mref(a[15:0],  c ? b[31:16] : b[15:0], s);
        @(negedge clk);
        chk({req, " R8 out_valid"}, out_valid, 1);
        chk({req, " R9 both enables"}, {hi_en, lo_en}, 2'b11);
        chk({req, " top product"}, hi_data, et);
        chk({req, " bottom product"}, lo_data, eb);
        chk({req, " R7 packed word"}, packed64, {et, eb});
        chk({req, " R9 packed no writes"}, {hi_en64, lo_en64}, 2'b00);
        in_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1; in_valid = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 out_valid in reset", {out_valid, v64}, 2'b00);
        chk("R10 enables in reset", {hi_en, lo_en}, 2'b00);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    task automatic t_straight();
        run_op(64'h0000_0000_1234_F00D, 64'h0000_0000_0456_8002, 1, 0, 5'd4, "R4 signed straight");
        run_op(64'h0000_0000_ABCD_0101, 64'h0000_0000_1357_FFFF, 0, 0, 5'd10, "R4 unsigned straight");
    endtask

    task automatic t_crossed();
        run_op(64'h0000_0000_7FFF_8001, 64'h0000_0000_0003_FFFE, 1, 1, 5'd8, "R5 signed crossed");
        run_op(64'h0000_0000_0002_0003, 64'h0000_0000_0005_0007, 0, 1, 5'd12, "R5 unsigned crossed");
        chk("R5 crossed top literal", hi_data, 32'd14);
        chk("R5 crossed bottom literal", lo_data, 32'd15);
    endtask

    task automatic t_corners();
        run_op(64'h0000_0000_8000_FFFF, 64'h0000_0000_8000_FFFF, 1, 0, 5'd2, "R2 signed corners");
        chk("R2 8000*8000 signed", hi_data, 32'h4000_0000);
        chk("R2 FFFF*FFFF signed", lo_data, 32'h0000_0001);
        run_op(64'h0000_0000_FFFF_8000, 64'h0000_0000_FFFF_8000, 0, 0, 5'd2, "R3 unsigned corners");
        chk("R3 FFFF*FFFF unsigned", hi_data, 32'hFFFE_0001);
        chk("R3 8000*8000 unsigned", lo_data, 32'h4000_0000);
    endtask

    task automatic t_pair_addr();
        run_op(64'h0000_0000_0001_0002, 64'h0000_0000_0003_0004, 0, 0, 5'd7, "R6 odd index");
        chk("R6 hi addr idx7", hi_addr, 5'd7);
        chk("R6 lo addr idx7", lo_addr, 5'd6);
        run_op(64'h0000_0000_0001_0002, 64'h0000_0000_0003_0004, 0, 0, 5'd6, "R6 even index");
        chk("R6 hi addr idx6", hi_addr, 5'd7);
        chk("R6 lo addr idx6", lo_addr, 5'd6);
        run_op(64'h0000_0000_0009_0009, 64'h0000_0000_0009_0009, 0, 0, 5'd31, "R6 top pair");
        chk("R6 hi addr idx31", hi_addr, 5'd31);
        chk("R6 lo addr idx31", lo_addr, 5'd30);
        chk("R6 hi data top product", hi_data, 32'd81);
    endtask

    task automatic t_upper_ignored();
        run_op(64'hDEAD_BEEF_0010_FFF0, 64'hCAFE_F00D_0020_0003, 1, 0, 5'd0, "R1 upper garbage");
        chk("R1 packed with garbage", packed64, {32'h0000_0200, 32'hFFFF_FFD0});
        run_op(64'h0000_0000_0010_FFF0, 64'h0000_0000_0020_0003, 1, 0, 5'd0, "R1 upper zero");
        chk("R1 packed with zero", packed64, {32'h0000_0200, 32'hFFFF_FFD0});
    endtask

    task automatic t_idle_and_b2b();
        @(negedge clk);
        chk("R8 idle no valid", {out_valid, v64}, 2'b00);
        chk("R9 idle no enables", {hi_en, lo_en}, 2'b00);
        run_op(64'h0000_0000_0100_0200, 64'h0000_0000_0300_0400, 0, 0, 5'd3, "R8 back to back A");
        run_op(64'h0000_0000_FF00_0080, 64'h0000_0000_0002_FFFF, 1, 1, 5'd5, "R8 back to back B");
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        a64 = 64'h1; b64 = 64'h1; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        chk("R10 reset beats in_valid", {out_valid, v64}, 2'b00);
        chk("R10 reset enables low", {hi_en, lo_en}, 2'b00);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R10 stays idle after reset", out_valid, 0);
    endtask

    initial begin
        t_reset_state();
        t_straight();
        t_crossed();
        t_corners();
        t_pair_addr();
        t_upper_ignored();
        t_idle_and_b2b();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule